// File: doc/BRIEF.md
# NOR Flash Buffered Program Sequencer

This block runs one buffered-program operation on a parallel NOR flash bus. A client pulses `start` with a chunk start address and a length in bytes. The data sits in a small local word buffer that the block reads by index. The block then issues the two unlock writes and the buffer-load command, followed by the word-count cycle, the data words and the program-confirm command. After a fixed typical programming delay it polls the device's status until two consecutive reads agree. If the device does not settle before a timeout, the block writes a reset command to the chip base and reports failure.

Each bus access is a request held on `bus_wr` or `bus_rd` until the device side returns `bus_ack`. Strobe timing is left to the bus side. The bus width in bytes, the buffer depth and the delays in clock cycles are parameters. The two unlock addresses and the chip base address are configuration inputs.

Top module: `nbp_seq`

## Requirements
- R1: The first two bus accesses of an accepted request are writes: data 0xAA to `unlock_a`, then data 0x55 to `unlock_b`. Every command value sits in byte lane 0 (bits 7:0), and all other lanes of a command write are zero.
- R2: Next comes command 0x25 written to the chunk start address. After it comes the count cycle, written to the same address, whose value is (byte_len / BW) minus one when byte_len is a multiple of BW, and (byte_len / BW) otherwise.
- R3: Data word i is read from buffer index i and written to byte address start_addr + i*BW. There are count+1 data writes, in increasing i.
- R4: When byte_len is not a multiple of BW, the last data word keeps its buffer bytes in lanes below byte_len mod BW. Every higher lane, at bits 8k+7:8k, carries 0xFF.
- R5: Command 0x29 is written to the chunk start address immediately after the last data word.
- R6: No status read is issued until at least WAIT_TYP clock cycles after the confirm write is accepted. Status reads address the chunk start.
- R7: When two consecutive status reads return equal values, `done` pulses for one cycle, `busy` drops, and no further bus access follows. `done` and `fail` are never high together.
- R8: If the status has not settled once TIMEOUT cycles of polling have passed, the block writes 0xF0 to `chip_base`, then pulses `fail`.
- R9: A request with byte_len = 0 raises `fail` in the next cycle and issues no bus access.
- R10: A request longer than BUF_WORDS*BW bytes, or whose start address is not a multiple of BW, issues only the write of 0xF0 to `chip_base` and then pulses `fail`.
- R11: A bus request keeps its kind, address and write data unchanged until it is acknowledged. A write and a read are never requested together.
- R12: A `start` pulse while `busy` is high is ignored, and the ongoing sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| start_addr | input | AW | Chunk start byte address |
| byte_len | input | LEN_W | Chunk length in bytes |
| unlock_a | input | AW | First unlock address |
| unlock_b | input | AW | Second unlock address |
| chip_base | input | AW | Chip base address for the reset command |
| buf_idx | output | IDX_W | Local buffer word index being read |
| buf_data | input | 8*BW | Buffer word at `buf_idx` |
| bus_wr | output | 1 | Write request, held until acknowledged |
| bus_rd | output | 1 | Read request, held until acknowledged |
| bus_addr | output | AW | Byte address of the request |
| bus_wdata | output | 8*BW | Write data |
| bus_rdata | input | 8*BW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Request completed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on success |
| fail | output | 1 | One-cycle pulse on error |

## Verification
A wrong state or slot counter appears at the bus in the very next request. It shows up as a write to the wrong address, an out-of-order command, a mis-sized count or a missing 0xFF lane. The reference model flags it on the acknowledge cycle of that transfer. Timer and poll-tracking faults show only after the confirm write, as an early status read, a wrong number of reads before `done`, or a missing reset write before `fail`. Those are checked within one poll interval of the error.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLK1,
        S_UNLK2,
        S_LOAD,
        S_COUNT,
        S_DATA,
        S_CONFIRM,
        S_WAIT,
        S_POLL_A,
        S_POLL_B,
        S_GAP,
        S_RESET
    } nbp_state_e;

    localparam logic [7:0] CMD_UNLK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLK2 = 8'h55;
    localparam logic [7:0] CMD_LOAD  = 8'h25;
    localparam logic [7:0] CMD_GO    = 8'h29;
    localparam logic [7:0] CMD_RST   = 8'hF0;

endpackage

// File: rtl/nbp_len_split.sv
// Splits a byte length into full words, leftover bytes and the index of
// the last word slot (which is also the value of the count cycle).
module nbp_len_split #(
    parameter int BW    = 2,
    parameter int LEN_W = 8,
    parameter int OFF_W = 1
) (
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] words,
    output logic [OFF_W-1:0] tail,
    output logic [LEN_W-1:0] last_slot
);
    localparam int SHIFT = $clog2(BW);

    generate
        if (BW == 1) begin : g_no_tail
            assign tail = '0;
        end else begin : g_tail
            assign tail = len[OFF_W-1:0];
        end
    endgenerate

    assign words     = len >> SHIFT;
    assign last_slot = (tail == '0) ? (words - 1'b1) : words;
endmodule

// File: rtl/nbp_word_pack.sv
// Fills the unused byte lanes of a trailing partial word with 0xFF.
module nbp_word_pack #(
    parameter int BW    = 2,
    parameter int OFF_W = 1
) (
    input  logic [8*BW-1:0] raw,
    input  logic [OFF_W-1:0] tail,
    input  logic             is_last,
    output logic [8*BW-1:0] word
);
    generate
        for (genvar k = 0; k < BW; k++) begin : g_lane
            logic keep;
            assign keep = !is_last || (tail == '0) ||
                          ({1'b0, tail} > (OFF_W+1)'(k));
            assign word[8*k +: 8] = keep ? raw[8*k +: 8] : 8'hFF;
        end
    endgenerate
endmodule

// File: rtl/nbp_timer.sv
// Loadable down-counter; expired while the count rests at zero.
module nbp_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbp_seq.sv
module nbp_seq
    import nbp_pkg::*;
#(
    parameter int BW        = 2,
    parameter int AW        = 24,
    parameter int BUF_WORDS = 16,
    parameter int LEN_W     = 8,
    parameter int WAIT_TYP  = 20,
    parameter int POLL_GAP  = 3,
    parameter int TIMEOUT   = 60,
    localparam int DW       = 8 * BW,
    localparam int IDX_W    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [AW-1:0]    unlock_a,
    input  logic [AW-1:0]    unlock_b,
    input  logic [AW-1:0]    chip_base,
    output logic [IDX_W-1:0] buf_idx,
    input  logic [DW-1:0]    buf_data,
    output logic             bus_wr,
    output logic             bus_rd,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ack,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    localparam int OFF_W     = (BW > 1) ? $clog2(BW) : 1;
    localparam int SHIFT     = $clog2(BW);
    localparam int MAX_BYTES = BUF_WORDS * BW;
    localparam int TIM_MAX   = (WAIT_TYP > POLL_GAP) ? WAIT_TYP : POLL_GAP;
    localparam int TIM_W     = $clog2(TIM_MAX + 1);
    localparam int TMO_W     = $clog2(TIMEOUT + 1);
    localparam bit BW_OK     = (BW == 1) || (BW == 2) || (BW == 4) || (BW == 8);
    localparam logic [AW-1:0] ALIGN_MASK = AW'(BW - 1);

    typedef struct packed {
        nbp_state_e        st;
        logic [AW-1:0]     addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  slot;
        logic [DW-1:0]     prev;
        logic [TMO_W-1:0]  tmo;
        logic              done;
        logic              fail;
    } regs_t;

    regs_t r_d, r_q;

    logic [LEN_W-1:0] words;
    logic [OFF_W-1:0] tail;
    logic [LEN_W-1:0] last_slot;
    logic [DW-1:0]    packed_word;
    logic             is_last;
    logic             tim_load;
    logic [TIM_W-1:0] tim_val;
    logic             tim_expired;

    nbp_len_split #(.BW(BW), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_split (
        .len       (r_q.len),
        .words     (words),
        .tail      (tail),
        .last_slot (last_slot)
    );

    assign is_last = (r_q.slot == last_slot);

    nbp_word_pack #(.BW(BW), .OFF_W(OFF_W)) u_pack (
        .raw     (buf_data),
        .tail    (tail),
        .is_last (is_last),
        .word    (packed_word)
    );

    nbp_timer #(.W(TIM_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tim_load),
        .load_val (tim_val),
        .expired  (tim_expired)
    );

    // Bus request derived from the current state
    always_comb begin
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = r_q.addr;
        bus_wdata = '0;
        unique case (r_q.st)
            S_UNLK1: begin
                bus_wr = 1'b1; bus_addr = unlock_a; bus_wdata = DW'(CMD_UNLK1);
            end
            S_UNLK2: begin
                bus_wr = 1'b1; bus_addr = unlock_b; bus_wdata = DW'(CMD_UNLK2);
            end
            S_LOAD: begin
                bus_wr = 1'b1; bus_wdata = DW'(CMD_LOAD);
            end
            S_COUNT: begin
                bus_wr = 1'b1; bus_wdata = DW'(last_slot);
            end
            S_DATA: begin
                bus_wr    = 1'b1;
                bus_addr  = r_q.addr + (AW'(r_q.slot) << SHIFT);
                bus_wdata = packed_word;
            end
            S_CONFIRM: begin
                bus_wr = 1'b1; bus_wdata = DW'(CMD_GO);
            end
            S_POLL_A, S_POLL_B: begin
                bus_rd = 1'b1;
            end
            S_RESET: begin
                bus_wr = 1'b1; bus_addr = chip_base; bus_wdata = DW'(CMD_RST);
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.fail = 1'b0;
        tim_load = 1'b0;
        tim_val  = '0;

        if ((r_q.st == S_POLL_A || r_q.st == S_POLL_B || r_q.st == S_GAP) &&
            (r_q.tmo < TMO_W'(TIMEOUT)))
            r_d.tmo = r_q.tmo + 1'b1;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.addr = start_addr;
                    r_d.len  = byte_len;
                    r_d.slot = '0;
                    if (byte_len == '0)
                        r_d.fail = 1'b1;
                    else if (!BW_OK || (32'(byte_len) > 32'(MAX_BYTES)) ||
                             ((start_addr & ALIGN_MASK) != '0))
                        r_d.st = S_RESET;
                    else
                        r_d.st = S_UNLK1;
                end
            end
            S_UNLK1: if (bus_ack) r_d.st = S_UNLK2;
            S_UNLK2: if (bus_ack) r_d.st = S_LOAD;
            S_LOAD:  if (bus_ack) r_d.st = S_COUNT;
            S_COUNT: if (bus_ack) r_d.st = S_DATA;
            S_DATA: begin
                if (bus_ack) begin
                    if (is_last) r_d.st = S_CONFIRM;
                    else         r_d.slot = r_q.slot + 1'b1;
                end
            end
            S_CONFIRM: begin
                if (bus_ack) begin
                    r_d.st   = S_WAIT;
                    tim_load = 1'b1;
                    tim_val  = TIM_W'(WAIT_TYP);
                end
            end
            S_WAIT: begin
                if (tim_expired) begin
                    r_d.st  = S_POLL_A;
                    r_d.tmo = '0;
                end
            end
            S_POLL_A: begin
                if (bus_ack) begin
                    r_d.prev = bus_rdata;
                    r_d.st   = S_POLL_B;
                end
            end
            S_POLL_B: begin
                if (bus_ack) begin
                    if (bus_rdata == r_q.prev) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.prev = bus_rdata;
                        if (r_q.tmo >= TMO_W'(TIMEOUT)) begin
                            r_d.st = S_RESET;
                        end else begin
                            r_d.st   = S_GAP;
                            tim_load = 1'b1;
                            tim_val  = TIM_W'(POLL_GAP);
                        end
                    end
                end
            end
            S_GAP: if (tim_expired) r_d.st = S_POLL_B;
            S_RESET: begin
                if (bus_ack) begin
                    r_d.st   = S_IDLE;
                    r_d.fail = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, addr: '0, len: '0, slot: '0,
                     prev: '0, tmo: '0, done: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_idx = r_q.slot[IDX_W-1:0];
    assign busy    = (r_q.st != S_IDLE);
    assign done    = r_q.done;
    assign fail    = r_q.fail;

    // Assertions
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_ack) |=>
            ($stable(bus_wr) && $stable(bus_rd) &&
             $stable(bus_addr) && $stable(bus_wdata)));

    assert_wr_rd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    assert_done_fail_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd && bus_ack));

    assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_len == '0) |=> (fail && !busy && !bus_wr && !bus_rd));

    assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(busy)) |->
            $past(bus_wr && bus_ack && bus_addr == chip_base &&
                  bus_wdata[7:0] == CMD_RST));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd));
endmodule

// File: tb/nbp_seq_bench.sv
`timescale 1ns/1ps
module nbp_seq_bench;
    localparam int BW = 2, AW = 24, BUF_WORDS = 16, LEN_W = 8;
    localparam int WAIT_TYP = 20, POLL_GAP = 3, TIMEOUT = 60;
    localparam int DW = 8 * BW;
    localparam int IDX_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LEN_W-1:0] byte_len = '0;
    logic [AW-1:0] unlock_a = 24'h000AAA;
    logic [AW-1:0] unlock_b = 24'h000554;
    logic [AW-1:0] chip_base = 24'h400000;
    logic [IDX_W-1:0] buf_idx;
    logic [DW-1:0] buf_data;
    logic bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_ack = 1'b0;
    logic busy, done, fail;

    logic [DW-1:0] bmem [BUF_WORDS];
    assign buf_data = bmem[buf_idx];

    always #2.5 clk = ~clk;

    nbp_seq #(.BW(BW), .AW(AW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W),
              .WAIT_TYP(WAIT_TYP), .POLL_GAP(POLL_GAP), .TIMEOUT(TIMEOUT)) u_nbp_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_len(byte_len), .unlock_a(unlock_a), .unlock_b(unlock_b),
        .chip_base(chip_base), .buf_idx(buf_idx), .buf_data(buf_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .fail(fail));

    int total = 0, bad = 0;
    int cyc = 0;
    int toggles = 0;
    int rd_count = 0;
    int txn_n = 0;
    int confirm_cyc = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [AW-1:0] exp_a [$];
    logic [DW-1:0] exp_d [$];
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] status_of(input int k);
        int p;
        p = (k < toggles) ? (k % 2) : (toggles % 2);
        return (p != 0) ? 16'h00C0 : 16'h0080;
    endfunction

    // Device side and per-clock comparison with the expected write stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && fail) chk(1'b0, "R7", "done and fail together", 1, 0);
            if (bus_wr && bus_rd) chk(1'b0, "R11", "write and read together", 1, 0);
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_wr) begin
            txn_n++;
            if (exp_a.size() == 0) begin
                chk(1'b0, "R1", "unexpected write", longint'(bus_addr), 0);
            end else begin
                chk(bus_addr == exp_a[0], "R3", "write address",
                    longint'(bus_addr), longint'(exp_a[0]));
                chk(bus_wdata == exp_d[0], "R4", "write data",
                    longint'(bus_wdata), longint'(exp_d[0]));
                void'(exp_a.pop_front());
                void'(exp_d.pop_front());
            end
            if (bus_wdata == 16'h0029) confirm_cyc = cyc;
            bus_ack = 1'b1;
        end else if (bus_rd) begin
            txn_n++;
            chk(bus_addr == cur_addr, "R6", "status read address",
                longint'(bus_addr), longint'(cur_addr));
            if (rd_count == 0)
                chk((cyc - confirm_cyc) >= WAIT_TYP, "R6", "early status read",
                    longint'(cyc - confirm_cyc), longint'(WAIT_TYP));
            bus_rdata = status_of(rd_count);
            rd_count++;
            bus_ack = 1'b1;
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
    endtask

    // kind: 0 = success, 1 = timeout, 2 = rejected with reset, 3 = zero length
    task automatic run(input logic [AW-1:0] sa, input int len, input int tg,
                       input int kind, input bit poke, input string tag);
        int words, tl, slots, waited, txn0;
        logic [DW-1:0] w;
        bit got_done, got_fail;
        toggles = tg;
        rd_count = 0;
        cur_addr = sa;
        exp_a.delete();
        exp_d.delete();
        for (int i = 0; i < BUF_WORDS; i++) bmem[i] = DW'(16'h1357 * (i + 3) + len);
        words = len / BW;
        tl = len % BW;
        slots = words + ((tl != 0) ? 1 : 0);
        if (kind <= 1) begin
            push(unlock_a, 16'h00AA);
            push(unlock_b, 16'h0055);
            push(sa, 16'h0025);
            push(sa, DW'(words - ((tl == 0) ? 1 : 0)));
            for (int i = 0; i < slots; i++) begin
                w = bmem[i];
                if (i == slots - 1 && tl != 0)
                    for (int k = tl; k < BW; k++) w[8*k +: 8] = 8'hFF;
                push(sa + AW'(i * BW), w);
            end
            push(sa, 16'h0029);
        end
        if (kind == 1 || kind == 2) push(chip_base, 16'h00F0);
        txn0 = txn_n;
        @(negedge clk);
        start_addr = sa;
        byte_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start_addr = sa + 24'h100;
            byte_len = 8'd4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got_done = 1'b0;
        got_fail = 1'b0;
        waited = 0;
        while (!got_done && !got_fail && waited < 3000) begin
            if (done) got_done = 1'b1;
            if (fail) got_fail = 1'b1;
            if (!got_done && !got_fail) begin
                @(negedge clk);
                waited++;
            end
        end
        if (kind == 0) begin
            chk(got_done && !got_fail, "R7", {tag, " done outcome"}, got_done, 1);
            chk(rd_count == tg + 2, "R7", {tag, " status reads"}, rd_count, tg + 2);
        end else begin
            chk(got_fail && !got_done, (kind == 1) ? "R8" : (kind == 2) ? "R10" : "R9",
                {tag, " fail outcome"}, got_fail, 1);
        end
        if (kind == 3)
            chk(txn_n == txn0, "R9", {tag, " bus quiet"}, txn_n - txn0, 0);
        if (kind == 2)
            chk(rd_count == 0 && txn_n - txn0 == 1, "R10", {tag, " only reset write"},
                txn_n - txn0, 1);
        chk(exp_a.size() == 0, (kind == 1) ? "R8" : "R5", {tag, " writes pending"},
            exp_a.size(), 0);
        txn0 = txn_n;
        @(negedge clk);
        chk(!busy, "R7", {tag, " busy after end"}, busy, 0);
        repeat (5) @(negedge clk);
        chk(txn_n == txn0, (poke) ? "R12" : "R7", {tag, " no trailing access"},
            txn_n - txn0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !bus_wr && !bus_rd, "R11", "reset state",
            {busy, done, fail, bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run(24'h001000, 32, 0, 0, 1'b0, "R2 full buffer");
        run(24'h002000, 7, 3, 0, 1'b0, "R4 odd length");
        run(24'h002100, 1, 1, 0, 1'b0, "R4 single byte");
        run(24'h002200, 2, 2, 0, 1'b0, "R2 single word");
        run(24'h003000, 10, 4, 0, 1'b1, "R12 busy start");
        run(24'h004000, 6, 1000, 1, 1'b0, "R8 timeout");
        run(24'h005000, 0, 0, 3, 1'b0, "R9 zero length");
        run(24'h006000, 33, 0, 2, 1'b0, "R10 oversize");
        run(24'h006001, 4, 0, 2, 1'b0, "R10 misaligned");
        run(24'h007000, 5, 0, 0, 1'b0, "R1 after errors");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule